// File: doc/BRIEF.md
# ROM-Socket Host Mailbox

This block sits behind a host CPU's ROM socket and answers every read in a 2 KB window. A ROM gives the host no write strobe, so the host sends data to the local parasite processor by reading from a dedicated page. The low eight address bits of that read are the byte sent. Data travelling the other way, together with status, comes back on the read data bus from a few fixed locations. Every other location in the window serves fixed ROM contents, so host software can find and run code held there.

The default build has two bidirectional byte channels. Each channel holds one byte in each direction, and each byte has its own full flag. The parasite side of each channel is a plain valid/ready byte stream. The host chip select is brought into the local clock domain by two flops. Each channel action fires on the falling edge of chip select, so a host read cycle of any length counts as exactly one access.

Top module: `rom_mailbox`

## Requirements
- R1: A host read at address `a` outside the last 8 bytes of the window returns `a[7:0] XOR ((a[10:8] * 37) mod 256)` on `host_rdata`, valid from the third clock after chip select falls with the address stable. `host_drive` is high from the second clock after `host_cs_n` falls until shortly after it rises.
- R2: A read anywhere in page 6 (0x600-0x6FF) loads `addr[7:0]` into the channel 0 host-to-parasite buffer. A read at 0x700-0x7F7 loads it into the channel 1 buffer. The byte is presented on `h2p_data` with `h2p_valid` high and held until accepted by `h2p_ready`.
- R3: One chip-select-low period makes exactly one channel write, however many clocks it lasts.
- R4: A write-page read while that channel's host-to-parasite buffer is full, and not being popped in the same cycle, is dropped. The buffer keeps its old byte and a sticky overrun flag is set, which only reset clears.
- R5: If the parasite pops a full host-to-parasite buffer in the same cycle as a new host write to that channel, the new byte is accepted with no overrun.
- R6: The status byte of channel k is at 0x7F8+2k. Bit 0 is host-to-parasite full, bit 1 is parasite-to-host available, bit 2 is overrun, and the other bits are 0.
- R7: The data location of channel k at 0x7F9+2k returns the parasite-to-host byte. Its available flag clears once per access, at the chip-select falling edge. A byte pushed later in the same access stays available. Status reads do not clear it.
- R8: `p2h_ready` of a channel is high exactly when its parasite-to-host buffer is empty. A push offered while the buffer is full is ignored.
- R9: The locations 0x7FC-0x7FF return 0. No read of the last 8 bytes and no ROM read loads any channel.
- R10: After reset no `h2p_valid` is high, all `p2h_ready` are high, `host_drive` is low and every status byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, faster than the host bus |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host address lines of the ROM window |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_rdata | output | 8 | Registered read data to the host |
| host_drive | output | 1 | High while the host data bus should be driven |
| h2p_valid | output | NUM_CH | Host-to-parasite byte present, one bit per channel |
| h2p_data | output | 8*NUM_CH | Host-to-parasite bytes, channel k in bits 8k+7:8k |
| h2p_ready | input | NUM_CH | Parasite accepts the host-to-parasite byte |
| p2h_valid | input | NUM_CH | Parasite offers a byte for the host |
| p2h_data | input | 8*NUM_CH | Parasite-to-host bytes, channel k in bits 8k+7:8k |
| p2h_ready | output | NUM_CH | Parasite-to-host buffer empty and accepting |

## Verification
Two pairs of events can land in the same clock. In the first, a host write-page read reaches a channel whose full buffer the parasite is popping. The bench raises `h2p_ready` for exactly the cycle in which the synchronized chip-select edge registers. It checks that the old byte was on the bus at that edge, that the new byte is now valid, and that the overrun bit stayed clear. In the second, a host data-location read overlaps a new parasite push. The bench holds chip select low, pushes a byte after the clear edge, and checks that the byte is still marked available once the access ends.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int BYTE_W    = 8;
  localparam int PAGE_OFFW = 8;   // 256-byte pages
  localparam int RSV_BYTES = 8;   // status/data block at top of window

  // status bit positions
  localparam int ST_H2P_FULL = 0;
  localparam int ST_P2H_AVL  = 1;
  localparam int ST_OVERRUN  = 2;

  // fixed ROM image: offset mixed with a page-dependent constant
  function automatic logic [7:0] rom_byte(input logic [7:0] page, input logic [7:0] off);
    logic [15:0] prod;
    prod = 16'(page) * 16'd37;
    return off ^ prod[7:0];
  endfunction
endpackage

// File: rtl/mbx_cs_sync.sv
module mbx_cs_sync (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_async,
  output logic cs_active,
  output logic cs_fall
);
  logic s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= cs_n_async;
      s2 <= s1;
    end
  end

  assign cs_active = ~s1;
  assign cs_fall   = s2 & ~s1;

  AST_ONE_EDGE_PER_ACCESS: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> !cs_fall); // R3
endmodule

// File: rtl/mbx_rom.sv
module mbx_rom #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = mbx_pkg::rom_byte(8'(i >> mbx_pkg::PAGE_OFFW), 8'(i));
  end

  always_ff @(posedge clk) rdata <= mem[addr];
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic [7:0] wr_byte,
  input  logic       rd_stb,
  output logic       h2p_valid,
  output logic [7:0] h2p_data,
  input  logic       h2p_ready,
  input  logic       p2h_valid,
  input  logic [7:0] p2h_data,
  output logic       p2h_ready,
  output logic [7:0] status,
  output logic [7:0] p2h_byte
);
  logic       h_full, ovr, p_avail;
  logic [7:0] h_data, p_data;
  logic       pop, push;

  assign pop  = h_full & h2p_ready;
  assign push = p2h_valid & ~p_avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_full <= 1'b0;
      h_data <= '0;
      ovr    <= 1'b0;
    end else if (wr_stb) begin
      if (!h_full || pop) begin
        h_data <= wr_byte;
        h_full <= 1'b1;
      end else begin
        ovr <= 1'b1;
      end
    end else if (pop) begin
      h_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_avail <= 1'b0;
      p_data  <= '0;
    end else if (push) begin
      p_data  <= p2h_data;
      p_avail <= 1'b1;
    end else if (rd_stb) begin
      p_avail <= 1'b0;
    end
  end

  assign h2p_valid = h_full;
  assign h2p_data  = h_data;
  assign p2h_ready = ~p_avail;
  assign p2h_byte  = p_data;

  always_comb begin
    status = '0;
    status[mbx_pkg::ST_H2P_FULL] = h_full;
    status[mbx_pkg::ST_P2H_AVL]  = p_avail;
    status[mbx_pkg::ST_OVERRUN]  = ovr;
  end

  AST_H2P_HELD: assert property (@(posedge clk) disable iff (rst)
    h2p_valid && !h2p_ready && !wr_stb |=> h2p_valid && $stable(h2p_data)); // R2
  AST_DROP_KEEPS_BYTE: assert property (@(posedge clk) disable iff (rst)
    wr_stb && h_full && !h2p_ready |=> $stable(h_data) && ovr); // R4
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovr |=> ovr); // R4
  AST_ACCEPT_ON_POP: assert property (@(posedge clk) disable iff (rst)
    wr_stb && pop |=> h_full && !$changed(ovr) && h_data == $past(wr_byte)); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rd_stb && p_avail |=> !p_avail); // R7
  AST_FULL_PUSH_IGNORED: assert property (@(posedge clk) disable iff (rst)
    p_avail && !rd_stb |=> $stable(p_data) && p_avail); // R8
endmodule

// File: rtl/rom_mailbox.sv
module rom_mailbox #(
  parameter int ADDR_W = 11,
  parameter int NUM_CH = 2    // at most 4 and at most the number of pages
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic                host_cs_n,
  output logic [7:0]          host_rdata,
  output logic                host_drive,
  output logic [NUM_CH-1:0]   h2p_valid,
  output logic [8*NUM_CH-1:0] h2p_data,
  input  logic [NUM_CH-1:0]   h2p_ready,
  input  logic [NUM_CH-1:0]   p2h_valid,
  input  logic [8*NUM_CH-1:0] p2h_data,
  output logic [NUM_CH-1:0]   p2h_ready
);
  localparam int PG_W     = ADDR_W - mbx_pkg::PAGE_OFFW;
  localparam int PAGES    = 1 << PG_W;
  localparam int RSV_LOC  = (1 << ADDR_W) - mbx_pkg::RSV_BYTES;
  localparam int RSV_W    = $clog2(mbx_pkg::RSV_BYTES);

  logic              cs_active, cs_fall;
  logic [PG_W-1:0]   page;
  logic              in_rsv;
  logic [NUM_CH-1:0] wr_stb, rd_stb;
  logic [7:0]        status  [NUM_CH];
  logic [7:0]        p2h_byte[NUM_CH];
  logic [7:0]        rom_q, rd_next;
  logic [ADDR_W-1:0] addr_q;

  mbx_cs_sync u_sync (
    .clk(clk), .rst(rst), .cs_n_async(host_cs_n),
    .cs_active(cs_active), .cs_fall(cs_fall)
  );

  mbx_rom #(.ADDR_W(ADDR_W)) u_rom (.clk(clk), .addr(host_addr), .rdata(rom_q));

  assign page   = host_addr[ADDR_W-1:mbx_pkg::PAGE_OFFW];
  assign in_rsv = (host_addr >= ADDR_W'(RSV_LOC));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam int WPG = PAGES - NUM_CH + k;
    assign wr_stb[k] = cs_fall && (page == PG_W'(WPG)) && !in_rsv;
    assign rd_stb[k] = cs_fall && (host_addr == ADDR_W'(RSV_LOC + 2*k + 1));

    mbx_chan u_chan (
      .clk(clk), .rst(rst),
      .wr_stb(wr_stb[k]), .wr_byte(host_addr[7:0]), .rd_stb(rd_stb[k]),
      .h2p_valid(h2p_valid[k]), .h2p_data(h2p_data[8*k +: 8]), .h2p_ready(h2p_ready[k]),
      .p2h_valid(p2h_valid[k]), .p2h_data(p2h_data[8*k +: 8]), .p2h_ready(p2h_ready[k]),
      .status(status[k]), .p2h_byte(p2h_byte[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= host_addr;
  end

  always_comb begin
    logic [RSV_W-1:0] idx;
    idx     = addr_q[RSV_W-1:0];
    rd_next = rom_q;
    if (addr_q >= ADDR_W'(RSV_LOC)) begin
      rd_next = '0;
      for (int k = 0; k < NUM_CH; k++) begin
        if (int'(idx) == 2*k)     rd_next = status[k];
        if (int'(idx) == 2*k + 1) rd_next = p2h_byte[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      host_drive <= 1'b0;
    end else begin
      host_rdata <= rd_next;
      host_drive <= cs_active;
    end
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_stb)); // R2
  AST_RSV_NEVER_WRITES: assert property (@(posedge clk) disable iff (rst)
    (rd_stb != '0) |-> (wr_stb == '0)); // R9
  AST_STROBES_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    ((wr_stb | rd_stb) != '0) |-> $rose(cs_active)); // R3
endmodule

// File: tb/rom_mailbox_test.sv
module rom_mailbox_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] host_addr = '0;
  logic        host_cs_n = 1'b1;
  logic [7:0]  host_rdata;
  logic        host_drive;
  logic [1:0]  h2p_valid;
  logic [15:0] h2p_data;
  logic [1:0]  h2p_ready = '0;
  logic [1:0]  p2h_valid = '0;
  logic [15:0] p2h_data  = '0;
  logic [1:0]  p2h_ready;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  rom_mailbox uut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_cs_n(host_cs_n),
    .host_rdata(host_rdata), .host_drive(host_drive),
    .h2p_valid(h2p_valid), .h2p_data(h2p_data), .h2p_ready(h2p_ready),
    .p2h_valid(p2h_valid), .p2h_data(p2h_data), .p2h_ready(p2h_ready)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rom(input logic [10:0] a);
    logic [15:0] p;
    p = 16'(a[10:8]) * 16'd37;
    return a[7:0] ^ p[7:0];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; host_cs_n = 1'b1; h2p_ready = '0; p2h_valid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic host_read(input logic [10:0] a, input int hold, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_cs_n = 1'b0;
    repeat (hold) @(posedge clk);
    @(negedge clk);
    d = host_rdata;
    host_cs_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pop(input int k);
    @(negedge clk); h2p_ready[k] = 1'b1;
    @(posedge clk);
    @(negedge clk); h2p_ready[k] = 1'b0;
  endtask

  task automatic push(input int k, input logic [7:0] b);
    @(negedge clk); p2h_valid[k] = 1'b1; p2h_data[8*k +: 8] = b;
    @(posedge clk);
    @(negedge clk); p2h_valid[k] = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk("R10 h2p_valid", 16'(h2p_valid), 16'h0);
    chk("R10 p2h_ready", 16'(p2h_ready), 16'h3);
    chk("R10 host_drive", 16'(host_drive), 16'h0);
    host_read(11'h7F8, 4, d); chk("R10 status ch0", 16'(d), 16'h00);
    host_read(11'h7FA, 4, d); chk("R10 status ch1", 16'(d), 16'h00);
  endtask

  task automatic t_rom();
    logic [7:0] d;
    logic [10:0] addrs [5] = '{11'h000, 11'h0FF, 11'h1A3, 11'h37C, 11'h5E0};
    do_reset();
    foreach (addrs[i]) begin
      host_read(addrs[i], 3, d);
      chk("R1 rom byte", 16'(d), 16'(exp_rom(addrs[i])));
    end
    @(negedge clk); host_addr = 11'h222; host_cs_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 drive not yet", 16'(host_drive), 16'h0);
    @(posedge clk); @(negedge clk);
    chk("R1 drive on", 16'(host_drive), 16'h1);
    host_cs_n = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R1 drive off", 16'(host_drive), 16'h0);
    chk("R9 rom reads no write", 16'(h2p_valid), 16'h0);
  endtask

  task automatic t_write();
    logic [7:0] d;
    do_reset();
    host_read(11'h6A5, 4, d);
    chk("R2 ch0 valid", 16'(h2p_valid), 16'h1);
    chk("R2 ch0 data", 16'(h2p_data[7:0]), 16'hA5);
    host_read(11'h742, 4, d);
    chk("R2 ch1 valid", 16'(h2p_valid), 16'h3);
    chk("R2 ch1 data", 16'(h2p_data[15:8]), 16'h42);
    host_read(11'h7F8, 4, d); chk("R6 status ch0 full", 16'(d), 16'h01);
    pop(0);
    chk("R2 ch0 popped", 16'(h2p_valid), 16'h2);
    chk("R2 ch1 held", 16'(h2p_data[15:8]), 16'h42);
    pop(1);
    chk("R2 ch1 popped", 16'(h2p_valid), 16'h0);
  endtask

  task automatic t_long();
    logic [7:0] d;
    do_reset();
    host_read(11'h611, 30, d);
    chk("R3 long access data", 16'(h2p_data[7:0]), 16'h11);
    host_read(11'h7F8, 4, d);
    chk("R3 single write no overrun", 16'(d), 16'h01);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    do_reset();
    host_read(11'h601, 4, d);
    host_read(11'h602, 4, d);
    chk("R4 byte kept", 16'(h2p_data[7:0]), 16'h01);
    host_read(11'h7F8, 4, d); chk("R4 overrun flag", 16'(d), 16'h05);
    pop(0);
    host_read(11'h603, 4, d);
    chk("R4 later write ok", 16'(h2p_data[7:0]), 16'h03);
    host_read(11'h7F8, 4, d); chk("R4 overrun sticky", 16'(d), 16'h05);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    do_reset();
    host_read(11'h610, 4, d);
    @(negedge clk); host_addr = 11'h620; host_cs_n = 1'b0;
    @(posedge clk);
    @(negedge clk); h2p_ready[0] = 1'b1;
    chk("R5 old byte at pop", 16'(h2p_data[7:0]), 16'h10);
    @(posedge clk);
    @(negedge clk); h2p_ready[0] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); host_cs_n = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R5 new byte valid", 16'(h2p_valid), 16'h1);
    chk("R5 new byte data", 16'(h2p_data[7:0]), 16'h20);
    host_read(11'h7F8, 4, d); chk("R5 no overrun", 16'(d), 16'h01);
  endtask

  task automatic t_p2h();
    logic [7:0] d;
    do_reset();
    push(1, 8'h9C);
    chk("R8 ready low when full", 16'(p2h_ready), 16'h1);
    push(1, 8'h33);
    host_read(11'h7FA, 4, d); chk("R6 status ch1 avail", 16'(d), 16'h02);
    host_read(11'h7FA, 4, d); chk("R7 status read keeps avail", 16'(d), 16'h02);
    host_read(11'h7F8, 4, d); chk("R6 status ch0 idle", 16'(d), 16'h00);
    host_read(11'h7FB, 4, d); chk("R8 push while full ignored", 16'(d), 16'h9C);
    chk("R7 avail cleared", 16'(p2h_ready), 16'h3);
    host_read(11'h7FA, 4, d); chk("R7 status after data read", 16'(d), 16'h00);
    @(negedge clk); host_addr = 11'h7FB; host_cs_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R7 ready during access", 16'(p2h_ready[1]), 16'h1);
    p2h_valid[1] = 1'b1; p2h_data[15:8] = 8'h5E;
    @(posedge clk);
    @(negedge clk); p2h_valid[1] = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R7 live byte", 16'(host_rdata), 16'h5E);
    host_cs_n = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    host_read(11'h7FA, 4, d); chk("R7 cleared once per access", 16'(d), 16'h02);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    do_reset();
    for (int a = 11'h7FC; a <= 11'h7FF; a++) begin
      host_read(11'(a), 4, d);
      chk("R9 reserved reads zero", 16'(d), 16'h00);
    end
    host_read(11'h7F8, 4, d);
    host_read(11'h7F9, 4, d);
    chk("R9 no write from reserved", 16'(h2p_valid), 16'h0);
    host_read(11'h7F7, 4, d);
    chk("R2 last write offset", 16'(h2p_data[15:8]), 16'hF7);
  endtask

  initial begin
    t_reset();
    t_rom();
    t_write();
    t_long();
    t_overrun();
    t_same_cycle();
    t_p2h();
    t_reserved();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule